// File: doc/BRIEF.md
# Line-Doubling Frame Buffer Fetcher

The block works out, for each displayed line of a raster, where that line's pixels start in memory and how many 64-bit words a reader must fetch for it. It holds a frame base address and a line pitch in bytes. For every horizontal sync leading edge that falls inside the vertical active region it issues one read request, made of an address and a burst length. The pitch can be larger than the bytes a line actually uses, so padded or sub-rectangle buffers work. An optional line-doubling mode issues every source line twice before it advances.

Software writes the next buffer's base into a pending register. The block adopts that value only at the start of the next active frame, so a swap never tears a frame. A pending base of zero marks "no buffer": the whole frame then issues no requests, and downstream logic shows black. A free-running frame counter and a consumed flag let software see when a swap has taken effect. The memory and the pixel serialiser sit outside this block.

Top module: `fbf_fetcher`

## Requirements
- R1: After reset, req_valid is 0, frame_count is 0, base_consumed is 0 and the pending base is 0. Line starts before the first frame start issue no request.
- R2: req_len equals ceil(E × B / 64). E is cfg_width, or floor(cfg_width / 2) when cfg_hdouble is 1. B is 4 when cfg_pix_mode is 0 and 1 when cfg_pix_mode is 1.
- R3: A line_start that is high while in_active is high, in a frame whose base is non-zero, gives req_valid high for exactly one cycle, on the cycle after line_start. req_addr then carries the current line address.
- R4: With cfg_vdouble at 0, the first request of a frame carries the frame base. Each later request carries the previous address plus cfg_pitch, modulo 2^ADDR_W.
- R5: With cfg_vdouble at 1, each line address is issued on two consecutive requests. The address then advances by cfg_pitch, and the pairing restarts at every frame start.
- R6: A base_wr changes only the pending base. Requests already in the current frame keep their address sequence until the next frame_start.
- R7: If the pending base is zero when frame_start occurs, no request is issued until the next frame_start.
- R8: frame_count increments by one on every frame_start, whether the base is zero or not, and wraps modulo 2^CNT_W.
- R9: base_consumed goes to 1 on frame_start and to 0 on base_wr. When both occur in the same cycle, the frame adopts the old pending value and base_consumed ends at 0.
- R10: A line_start with in_active low issues no request. A line_start in the same cycle as frame_start also issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | WIDTH_W | Active line width in pixels |
| cfg_pix_mode | input | 1 | 0 = 4 bits per pixel, 1 = 1 bit per pixel |
| cfg_hdouble | input | 1 | Halve the fetched width (horizontal doubling) |
| cfg_vdouble | input | 1 | Issue each source line twice |
| cfg_pitch | input | PITCH_W | Byte distance between source lines |
| base_wr | input | 1 | Write strobe for the pending base |
| base_data | input | ADDR_W | New pending base address |
| frame_start | input | 1 | Start-of-active-frame pulse |
| line_start | input | 1 | Horizontal sync leading-edge pulse |
| in_active | input | 1 | High inside the vertical active region |
| req_valid | output | 1 | Read request strobe |
| req_addr | output | ADDR_W | Byte address of the line |
| req_len | output | WIDTH_W-3 | Burst length in 64-bit words |
| frame_count | output | CNT_W | Frames started, wrapping |
| base_consumed | output | 1 | Pending base has been adopted |

## Verification
The bench aims at the widths whose bit count is not a multiple of 64. A burst length that truncates instead of rounding up would drop the last word of 4-bpp lines 100 pixels wide and of halved 101-pixel lines. It drives a base write in the middle of a frame; a design that swapped at once would jump the address sequence mid-frame. It drives a zero base, where a wrong design would fetch from address zero, and a write that lands in the same cycle as frame_start, where a wrong design would adopt the new value or leave the consumed flag set. It also drives line-doubling pairs across a frame boundary, line starts that coincide with frame_start, and a counter wrap. In each of these a wrong design issues a stray request, misses an advance, or shows a count off by one.

// File: rtl/fbf_pkg.sv
// Package: shared types for the frame buffer fetcher.
// Assumes nothing beyond a 1-bit pixel-depth select.
package fbf_pkg;
    typedef enum logic {
        PIX_4BPP = 1'b0,
        PIX_1BPP = 1'b1
    } pix_mode_e;
endpackage

// File: rtl/fbf_words.sv
// Module: fbf_words
// Computes the 64-bit word count of one line from width, doubling and depth.
// Assumes LEN_W == WIDTH_W - 3, which holds the largest count at 4 bpp.
module fbf_words #(
    parameter int WIDTH_W = 12,
    parameter int LEN_W   = WIDTH_W - 3
) (
    input  logic [WIDTH_W-1:0] width_px,
    input  logic               hdouble,
    input  fbf_pkg::pix_mode_e mode,
    output logic [LEN_W-1:0]   words
);
    localparam int BITS_W = WIDTH_W + 3;

    logic [WIDTH_W-1:0] eff_w;
    logic [BITS_W-1:0]  line_bits;
    logic [BITS_W-1:0]  rounded;

    // Effective width, line bit count and rounded-up word count.
    always_comb begin
        eff_w     = hdouble ? (width_px >> 1) : width_px;
        line_bits = (mode == fbf_pkg::PIX_4BPP) ? {1'b0, eff_w, 2'b00}
                                                : {3'b000, eff_w};
        rounded   = line_bits + BITS_W'(63);
        words     = rounded[BITS_W-1:6];
    end
endmodule

// File: rtl/fbf_frame_ctl.sv
// Module: fbf_frame_ctl
// Holds the pending base, decides at frame start whether the frame is live,
// counts frames and keeps the consumed flag.
// Assumes frame_start and base_wr are single-cycle pulses.
module fbf_frame_ctl #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_data,
    input  logic              frame_start,
    output logic [ADDR_W-1:0] pending_base,
    output logic              frame_live,
    output logic [CNT_W-1:0]  frame_count,
    output logic              consumed
);
    // Pending register, live flag, counter and consumed flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_base <= '0;
            frame_live   <= 1'b0;
            frame_count  <= '0;
            consumed     <= 1'b0;
        end else begin
            if (frame_start) begin
                frame_live  <= (pending_base != '0);
                frame_count <= frame_count + 1'b1;
            end
            if (base_wr) begin
                pending_base <= base_data;
            end
            if (base_wr) begin
                consumed <= 1'b0;
            end else if (frame_start) begin
                consumed <= 1'b1;
            end
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> frame_count == $past(frame_count) + 1'b1); // R8
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_count)); // R8
    AST_CONSUMED_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> !consumed); // R9
    AST_LIVE_ONLY_START: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(frame_live)); // R7
endmodule

// File: rtl/fbf_line_seq.sv
// Module: fbf_line_seq
// Walks the line address through a frame and issues one request per
// qualified line start, replaying each address twice in doubling mode.
// Assumes load_base is the pending base seen in the frame_start cycle.
module fbf_line_seq #(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int LEN_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic [ADDR_W-1:0]  load_base,
    input  logic               frame_live,
    input  logic               line_start,
    input  logic               in_active,
    input  logic               vdouble,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [LEN_W-1:0]   words,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_len
);
    logic [ADDR_W-1:0] line_addr;
    logic              replay;
    logic              fire;
    logic [ADDR_W-1:0] pitch_ext;

    // Qualify a line start and widen the pitch.
    always_comb begin
        fire      = line_start && in_active && frame_live && !frame_start;
        pitch_ext = ADDR_W'(pitch);
    end

    // Register the request and step the line address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_addr <= '0;
            replay    <= 1'b0;
            req_valid <= 1'b0;
            req_addr  <= '0;
            req_len   <= '0;
        end else begin
            req_valid <= fire;
            if (fire) begin
                req_addr <= line_addr;
                req_len  <= words;
            end
            if (frame_start) begin
                line_addr <= load_base;
                replay    <= 1'b0;
            end else if (fire) begin
                if (!vdouble || replay) begin
                    line_addr <= line_addr + pitch_ext;
                    replay    <= 1'b0;
                end else begin
                    replay    <= 1'b1;
                end
            end
        end
    end

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(line_start && in_active)); // R3
    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !req_valid); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !fire) |=> $stable(line_addr)); // R6
    AST_DOUBLE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && vdouble && !replay) |=> $stable(line_addr)); // R5
endmodule

// File: rtl/fbf_fetcher.sv
// Module: fbf_fetcher (top)
// Frame buffer fetcher: turns sync pulses into line read requests of
// address plus 64-bit word count, with a frame-synchronous buffer swap.
// Assumes all control inputs are synchronous to clk and pulses last one cycle.
module fbf_fetcher #(
    parameter int ADDR_W  = 32,
    parameter int WIDTH_W = 12,
    parameter int PITCH_W = 16,
    parameter int CNT_W   = 8,
    localparam int LEN_W  = WIDTH_W - 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH_W-1:0] cfg_width,
    input  logic               cfg_pix_mode,
    input  logic               cfg_hdouble,
    input  logic               cfg_vdouble,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic               base_wr,
    input  logic [ADDR_W-1:0]  base_data,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic               in_active,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [LEN_W-1:0]   req_len,
    output logic [CNT_W-1:0]   frame_count,
    output logic               base_consumed
);
    fbf_pkg::pix_mode_e pix_mode;
    logic [LEN_W-1:0]   line_words;
    logic [ADDR_W-1:0]  pending_base;
    logic               frame_live;

    // Map the raw depth pin onto the enumerated mode.
    always_comb begin
        pix_mode = fbf_pkg::pix_mode_e'(cfg_pix_mode);
    end

    fbf_words #(.WIDTH_W(WIDTH_W), .LEN_W(LEN_W)) u_words (
        .width_px (cfg_width),
        .hdouble  (cfg_hdouble),
        .mode     (pix_mode),
        .words    (line_words)
    );

    fbf_frame_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .base_wr      (base_wr),
        .base_data    (base_data),
        .frame_start  (frame_start),
        .pending_base (pending_base),
        .frame_live   (frame_live),
        .frame_count  (frame_count),
        .consumed     (base_consumed)
    );

    fbf_line_seq #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .LEN_W(LEN_W)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .load_base   (pending_base),
        .frame_live  (frame_live),
        .line_start  (line_start),
        .in_active   (in_active),
        .vdouble     (cfg_vdouble),
        .pitch       (cfg_pitch),
        .words       (line_words),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_len     (req_len)
    );

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid || $past(line_start)); // R3
endmodule

// File: tb/fbf_fetcher_tb.sv
module fbf_fetcher_tb;
    localparam int ADDR_W  = 32;
    localparam int WIDTH_W = 12;
    localparam int PITCH_W = 16;
    localparam int CNT_W   = 8;
    localparam int LEN_W   = WIDTH_W - 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [WIDTH_W-1:0] cfg_width = '0;
    logic               cfg_pix_mode = 1'b0;
    logic               cfg_hdouble = 1'b0;
    logic               cfg_vdouble = 1'b0;
    logic [PITCH_W-1:0] cfg_pitch = '0;
    logic               base_wr = 1'b0;
    logic [ADDR_W-1:0]  base_data = '0;
    logic               frame_start = 1'b0;
    logic               line_start = 1'b0;
    logic               in_active = 1'b0;
    logic               req_valid;
    logic [ADDR_W-1:0]  req_addr;
    logic [LEN_W-1:0]   req_len;
    logic [CNT_W-1:0]   frame_count;
    logic               base_consumed;

    int n_chk = 0;
    int n_bad = 0;

    // scoreboard of expected {addr, len}
    logic [ADDR_W+LEN_W-1:0] exp_q[$];

    // reference model state
    logic [ADDR_W-1:0] m_pend = '0;
    logic [ADDR_W-1:0] m_line = '0;
    logic              m_phase = 1'b0;
    logic              m_live = 1'b0;
    logic [CNT_W-1:0]  m_cnt = '0;
    logic              m_cons = 1'b0;

    always #2 clk = ~clk;

    fbf_fetcher #(.ADDR_W(ADDR_W), .WIDTH_W(WIDTH_W), .PITCH_W(PITCH_W),
                  .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width),
        .cfg_pix_mode(cfg_pix_mode), .cfg_hdouble(cfg_hdouble),
        .cfg_vdouble(cfg_vdouble), .cfg_pitch(cfg_pitch),
        .base_wr(base_wr), .base_data(base_data),
        .frame_start(frame_start), .line_start(line_start),
        .in_active(in_active), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .frame_count(frame_count),
        .base_consumed(base_consumed)
    );

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R2 word count from the requirement
    function automatic logic [LEN_W-1:0] exp_words();
        int eff;
        int bits;
        eff  = cfg_hdouble ? int'(cfg_width) / 2 : int'(cfg_width);
        bits = cfg_pix_mode ? eff : eff * 4;
        return LEN_W'((bits + 63) / 64);
    endfunction

    // monitor: pop and compare every request
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10/R7 unexpected request", longint'(req_addr), 0);
            end else begin
                logic [ADDR_W+LEN_W-1:0] e;
                e = exp_q.pop_front();
                check(req_addr == e[ADDR_W+LEN_W-1:LEN_W], "R3 R4 R5 address",
                      longint'(req_addr), longint'(e[ADDR_W+LEN_W-1:LEN_W]));
                check(req_len == e[LEN_W-1:0], "R2 burst length",
                      longint'(req_len), longint'(e[LEN_W-1:0]));
            end
        end
    end

    task automatic write_base(input logic [ADDR_W-1:0] v);
        @(negedge clk);
        base_wr = 1'b1; base_data = v;
        @(negedge clk);
        base_wr = 1'b0;
        m_pend = v; m_cons = 1'b0;
    endtask

    task automatic start_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_line = m_pend; m_live = (m_pend != '0); m_phase = 1'b0;
        m_cnt = m_cnt + 1'b1; m_cons = 1'b1;
    endtask

    task automatic do_line(input logic act);
        @(negedge clk);
        line_start = 1'b1; in_active = act;
        if (act && m_live) begin
            exp_q.push_back({m_line, exp_words()});
            if (!cfg_vdouble || m_phase) begin
                m_line = m_line + ADDR_W'(cfg_pitch);
                m_phase = 1'b0;
            end else begin
                m_phase = 1'b1;
            end
        end
        @(negedge clk);
        line_start = 1'b0; in_active = 1'b0;
    endtask

    task automatic drain(input string tag);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic check_status(input string tag);
        check(frame_count == m_cnt, {tag, " R8 frame_count"}, frame_count, m_cnt);
        check(base_consumed == m_cons, {tag, " R9 consumed"}, base_consumed, m_cons);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
        check(frame_count == '0, "R1 frame_count", frame_count, 0);
        check(base_consumed == 1'b0, "R1 consumed", base_consumed, 0);
        do_line(1'b1);
        drain("R1 no request before first frame");

        // R4 plain walk, 640 px 4bpp, pitch larger than line bytes
        cfg_width = 12'd640; cfg_pitch = 16'd400;
        write_base(32'h0000_1000);
        check_status("R9 after write");
        start_frame();
        check_status("R8 first frame");
        repeat (3) do_line(1'b1);
        do_line(1'b0);               // R10 outside active region
        // R6 mid-frame write does not disturb the walk
        write_base(32'h0000_8000);
        do_line(1'b1);
        drain("R4 R6 R10 walk");
        check_status("R9 mid-frame write");

        // R5 doubling, 1bpp with horizontal halving
        cfg_vdouble = 1'b1; cfg_pix_mode = 1'b1; cfg_hdouble = 1'b1;
        start_frame();
        repeat (5) do_line(1'b1);
        start_frame();               // R5 pairing restarts
        repeat (3) do_line(1'b1);
        drain("R5 doubling");

        // R2 rounding corners
        cfg_vdouble = 1'b0; cfg_pix_mode = 1'b0; cfg_hdouble = 1'b0;
        cfg_width = 12'd100; do_line(1'b1);
        cfg_width = 12'd101; cfg_hdouble = 1'b1; do_line(1'b1);
        cfg_width = 12'd4095; cfg_hdouble = 1'b0; do_line(1'b1);
        cfg_width = 12'd64; cfg_pix_mode = 1'b1; do_line(1'b1);
        drain("R2 rounding");

        // R7 zero base blanks the frame
        cfg_width = 12'd320; cfg_pix_mode = 1'b0;
        write_base('0);
        start_frame();
        check_status("R7 zero frame");
        repeat (2) do_line(1'b1);
        drain("R7 no request in zero frame");
        write_base(32'h0000_0200);
        start_frame();
        do_line(1'b1);
        drain("R7 recovery");

        // R9 write and frame start in the same cycle
        @(negedge clk);
        base_wr = 1'b1; base_data = 32'h0000_3000; frame_start = 1'b1;
        @(negedge clk);
        base_wr = 1'b0; frame_start = 1'b0;
        m_line = m_pend; m_live = 1'b1; m_phase = 1'b0; m_cnt = m_cnt + 1'b1;
        m_pend = 32'h0000_3000; m_cons = 1'b0;
        check_status("R9 same-cycle");
        do_line(1'b1);
        start_frame();
        do_line(1'b1);
        drain("R9 old base then new base");

        // R10 line start coincident with frame start
        @(negedge clk);
        frame_start = 1'b1; line_start = 1'b1; in_active = 1'b1;
        @(negedge clk);
        frame_start = 1'b0; line_start = 1'b0; in_active = 1'b0;
        m_line = m_pend; m_phase = 1'b0; m_cnt = m_cnt + 1'b1; m_cons = 1'b1;
        do_line(1'b1);
        drain("R10 coincident line start ignored");

        // R8 wrap
        for (int i = 0; i < (1 << CNT_W); i++) start_frame();
        check_status("R8 after wrap");

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule